// File: doc/BRIEF.md
# Fetch Next-PC Predictor with Target Buffer and Direction Counters

This block sits in the instruction fetch stage and predicts the address to fetch next. It holds two tables. The first is a small, fully associative target buffer that records branches seen before and the target each one last took. The second is a larger, direct-mapped table of 2-bit saturating counters, indexed by low address bits, that supplies the direction verdict. A branch is predicted taken only when both tables agree: the target buffer must hold the address and the counter must lean taken. In every other case the prediction is the sequential address.

The prediction is combinational from `fetch_pc`. The back end reports a resolved branch through the update port, giving its address, its actual direction and its actual target. Both tables change on the clock edge that follows, and never at prediction time. A resolved taken branch that is not in the target buffer gets a new entry. Free entries are used first. When the buffer is full, entries are replaced in round-robin order.

Top module: `bp_next_pc`

## Requirements
- R1: After synchronous reset, every counter holds 1 (weakly not-taken) and the target buffer is empty, so every lookup gives `pred_taken`=0 and `pred_npc`=`fetch_pc`+4.
- R2: A lookup whose word address is not in the target buffer gives `pred_taken`=0 and `pred_npc`=`fetch_pc`+FETCH_BYTES (4 by default).
- R3: A lookup that hits the target buffer while its counter is 2 or 3 gives `pred_taken`=1, and `pred_npc` equals the stored target.
- R4: A lookup that hits the target buffer while its counter is 0 or 1 gives the sequential prediction. The counter verdict overrides the hit.
- R5: Each counter is 2 bits wide. A resolved taken branch adds 1 and saturates at 3. A resolved not-taken branch subtracts 1 and saturates at 0.
- R6: The counter index is `pc[10:2]` (512 counters). Branches whose addresses differ by a multiple of 2048 bytes share one counter.
- R7: Entries in the target buffer are tagged with the full word address `pc[31:2]`. Bits `pc[1:0]` are ignored on both lookup and update.
- R8: A resolved taken branch that misses the target buffer allocates an entry, taking the lowest-numbered free entry first.
- R9: When all 64 entries are valid, an allocation evicts entries in round-robin order, starting from entry 0. The valid count never decreases except at reset.
- R10: A resolved taken branch that hits the target buffer replaces its stored target. A resolved not-taken branch leaves the target buffer unchanged.
- R11: When an update and a lookup of the same address happen in the same cycle, the lookup sees the table contents from before the update.
- R12: No word address occupies more than one entry of the target buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| pred_taken | output | 1 | Predicted taken |
| pred_npc | output | PC_W | Predicted next fetch address |
| upd_valid | input | 1 | A branch resolved this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction of the resolved branch |
| upd_target | input | PC_W | Actual target of the resolved branch |

## Verification
Round-robin eviction is the hardest situation to reach, because it only happens after all 64 entries are valid. The stimulus fills the buffer with a run of taken branches at distinct word addresses, keeps allocating, and then looks up the oldest addresses to confirm which entries were evicted. Two other behaviours need careful setup. Counter aliasing needs two branches exactly 2048 bytes apart. The old-contents rule needs a lookup and an allocating update of the same address in the same cycle.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'd0,
        CTR_WNT = 2'd1,
        CTR_WT  = 2'd2,
        CTR_ST  = 2'd3
    } ctr_t;

    localparam ctr_t CTR_RESET = CTR_WNT;

    function automatic ctr_t ctr_step(ctr_t c, logic taken);
        ctr_t r;
        r = c;
        if (taken) begin
            if (c != CTR_ST) r = ctr_t'(c + 2'd1);
        end else begin
            if (c != CTR_SNT) r = ctr_t'(c - 2'd1);
        end
        return r;
    endfunction

    function automatic logic ctr_leans_taken(ctr_t c);
        return (c == CTR_WT) || (c == CTR_ST);
    endfunction

endpackage

// File: rtl/bp_dir_table.sv
module bp_dir_table
    import bp_pkg::*;
#(
    parameter int ENTRIES = 512,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    ctr_t tbl [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) tbl[i] <= CTR_RESET;
        end else if (wr_en) begin
            tbl[wr_idx] <= ctr_step(tbl[wr_idx], wr_taken);
        end
    end

    assign rd_taken = ctr_leans_taken(tbl[rd_idx]);

    // R5
    ctr_sat_high_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken && tbl[wr_idx] == CTR_ST) |=> tbl[$past(wr_idx)] == CTR_ST);

    // R5
    ctr_sat_low_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken && tbl[wr_idx] == CTR_SNT) |=> tbl[$past(wr_idx)] == CTR_SNT);

endmodule

// File: rtl/bp_target_cam.sv
module bp_target_cam #(
    parameter int ENTRIES = 64,
    parameter int TAG_W   = 30,
    parameter int ADDR_W  = 32,
    localparam int PTR_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_hit,
    output logic [ADDR_W-1:0] rd_target,
    input  logic              wr_en,
    input  logic              wr_taken,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_target
);

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [ADDR_W-1:0]  tgt_q [ENTRIES];
    logic [PTR_W-1:0]   rr_q;

    logic [ENTRIES-1:0] rd_match;
    logic [ENTRIES-1:0] wr_match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign rd_match[g] = valid_q[g] && (tag_q[g] == rd_tag);
        assign wr_match[g] = valid_q[g] && (tag_q[g] == wr_tag);
    end

    assign rd_hit = |rd_match;

    always_comb begin
        rd_target = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (rd_match[i]) rd_target = rd_target | tgt_q[i];
        end
    end

    logic             wr_hit;
    logic [PTR_W-1:0] wr_hit_idx;
    logic [PTR_W-1:0] free_idx;
    logic             full;
    logic             alloc;
    logic [PTR_W-1:0] victim;

    always_comb begin
        wr_hit_idx = '0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (wr_match[i]) wr_hit_idx = PTR_W'(i);
            if (!valid_q[i]) free_idx   = PTR_W'(i);
        end
    end

    assign wr_hit = |wr_match;
    assign full   = &valid_q;
    assign alloc  = wr_en && wr_taken && !wr_hit;
    assign victim = full ? rr_q : free_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            rr_q    <= '0;
        end else if (wr_en && wr_taken) begin
            if (wr_hit) begin
                tgt_q[wr_hit_idx] <= wr_target;
            end else begin
                valid_q[victim] <= 1'b1;
                tag_q[victim]   <= wr_tag;
                tgt_q[victim]   <= wr_target;
                if (full) rr_q <= (rr_q == PTR_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
            end
        end
    end

    // R12
    single_match_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rd_match));

    // R8
    alloc_lands_chk: assert property (@(posedge clk) disable iff (rst)
        alloc |=> (valid_q[$past(victim)] && tag_q[$past(victim)] == $past(wr_tag)));

    // R9
    valid_count_mono_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(valid_q) >= $countones($past(valid_q)));

endmodule

// File: rtl/bp_next_pc.sv
module bp_next_pc
    import bp_pkg::*;
#(
    parameter int PC_W        = 32,
    parameter int BTB_ENTRIES = 64,
    parameter int DIR_ENTRIES = 512,
    parameter int FETCH_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_taken,
    output logic [PC_W-1:0] pred_npc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target
);

    localparam int TAG_W = PC_W - 2;
    localparam int IDX_W = $clog2(DIR_ENTRIES);

    logic [TAG_W-1:0] rd_tag;
    logic [TAG_W-1:0] wr_tag;
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;
    logic [1:0]       upd_low_unused;

    assign rd_tag         = fetch_pc[PC_W-1:2];
    assign wr_tag         = upd_pc[PC_W-1:2];
    assign rd_idx         = fetch_pc[2 +: IDX_W];
    assign wr_idx         = upd_pc[2 +: IDX_W];
    assign upd_low_unused = upd_pc[1:0];

    logic            cam_hit;
    logic [PC_W-1:0] cam_target;
    logic            dir_taken;

    bp_target_cam #(
        .ENTRIES (BTB_ENTRIES),
        .TAG_W   (TAG_W),
        .ADDR_W  (PC_W)
    ) u_cam (
        .clk       (clk),
        .rst       (rst),
        .rd_tag    (rd_tag),
        .rd_hit    (cam_hit),
        .rd_target (cam_target),
        .wr_en     (upd_valid),
        .wr_taken  (upd_taken),
        .wr_tag    (wr_tag),
        .wr_target (upd_target)
    );

    bp_dir_table #(
        .ENTRIES (DIR_ENTRIES)
    ) u_dir (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (rd_idx),
        .rd_taken (dir_taken),
        .wr_en    (upd_valid),
        .wr_idx   (wr_idx),
        .wr_taken (upd_taken)
    );

    assign pred_taken = cam_hit && dir_taken;
    assign pred_npc   = pred_taken ? cam_target : fetch_pc + PC_W'(FETCH_BYTES);

endmodule

// File: tb/sim_bp_next_pc.sv
module sim_bp_next_pc;

    localparam int PC_W  = 32;
    localparam int BTB_N = 64;
    localparam int DIR_N = 512;

    logic            clk = 1'b0;
    logic            rst;
    logic [PC_W-1:0] fetch_pc;
    logic            pred_taken;
    logic [PC_W-1:0] pred_npc;
    logic            upd_valid;
    logic [PC_W-1:0] upd_pc;
    logic            upd_taken;
    logic [PC_W-1:0] upd_target;

    always #5 clk = ~clk;

    bp_next_pc u0 (
        .clk        (clk),
        .rst        (rst),
        .fetch_pc   (fetch_pc),
        .pred_taken (pred_taken),
        .pred_npc   (pred_npc),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_taken  (upd_taken),
        .upd_target (upd_target)
    );

    int checks = 0;
    int fails  = 0;

    // behavioural reference: counters as integers, buffer as a list of records
    int          m_ctr [DIR_N];
    bit          m_v   [BTB_N];
    logic [29:0] m_tag [BTB_N];
    logic [31:0] m_tgt [BTB_N];
    int          m_rr;

    task automatic model_reset();
        for (int i = 0; i < DIR_N; i++) m_ctr[i] = 1;
        for (int i = 0; i < BTB_N; i++) m_v[i] = 0;
        m_rr = 0;
    endtask

    function automatic int model_find(logic [31:0] pc);
        int h;
        h = -1;
        for (int i = 0; i < BTB_N; i++)
            if (m_v[i] && m_tag[i] == pc[31:2]) h = i;
        return h;
    endfunction

    task automatic model_update(logic [31:0] pc, bit tk, logic [31:0] tgt);
        int idx;
        int h;
        int slot;
        idx = int'(pc[10:2]);
        if (tk) m_ctr[idx] = (m_ctr[idx] < 3) ? m_ctr[idx] + 1 : 3;
        else    m_ctr[idx] = (m_ctr[idx] > 0) ? m_ctr[idx] - 1 : 0;
        if (tk) begin
            h = model_find(pc);
            if (h >= 0) m_tgt[h] = tgt;
            else begin
                slot = -1;
                for (int i = BTB_N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
                if (slot < 0) begin
                    slot = m_rr;
                    m_rr = (m_rr + 1) % BTB_N;
                end
                m_v[slot]   = 1;
                m_tag[slot] = pc[31:2];
                m_tgt[slot] = tgt;
            end
        end
    endtask

    task automatic step(string req, logic [31:0] fpc, bit uv, logic [31:0] upc, bit ut,
                        logic [31:0] utgt);
        int  h;
        bit  e_tk;
        logic [31:0] e_npc;
        @(negedge clk);
        fetch_pc   = fpc;
        upd_valid  = uv;
        upd_pc     = upc;
        upd_taken  = ut;
        upd_target = utgt;
        #1;
        h     = model_find(fpc);
        e_tk  = (h >= 0) && (m_ctr[int'(fpc[10:2])] >= 2);
        e_npc = e_tk ? m_tgt[h] : fpc + 32'd4;
        checks++;
        if (pred_taken !== e_tk) begin
            fails++;
            $display("FAIL %s pc=%h pred_taken act %0b exp %0b", req, fpc, pred_taken, e_tk);
        end
        checks++;
        if (pred_npc !== e_npc) begin
            fails++;
            $display("FAIL %s pc=%h pred_npc act %h exp %h", req, fpc, pred_npc, e_npc);
        end
        @(posedge clk);
        if (uv) model_update(upc, ut, utgt);
    endtask

    task automatic look(string req, logic [31:0] fpc);
        step(req, fpc, 1'b0, 32'h0, 1'b0, 32'h0);
    endtask

    task automatic upd(string req, logic [31:0] fpc, logic [31:0] upc, bit ut,
                       logic [31:0] utgt);
        step(req, fpc, 1'b1, upc, ut, utgt);
    endtask

    localparam logic [31:0] PA = 32'h0000_1000;
    localparam logic [31:0] PB = 32'h0000_1800;   // PA + 2048: shares PA's counter
    localparam logic [31:0] PC = 32'h0000_3000;

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; fetch_pc = '0; upd_valid = 0; upd_pc = '0; upd_taken = 0; upd_target = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state: all sequential
        look("R1", 32'h0000_0100);
        look("R1", PA);
        // R2 miss
        look("R2", 32'h0000_2004);

        // R8 allocation of a taken branch, then R3 hit with counter 2
        upd("R8", 32'h0000_0040, PA, 1'b1, 32'h0000_4000);
        look("R3", PA);

        // R4 counter back to 1 overrides the hit
        upd("R4", 32'h0000_0040, PA, 1'b0, 32'h0000_4000);
        look("R4", PA);

        // R5 saturation at the top
        for (int i = 0; i < 4; i++) upd("R5", PA, PA, 1'b1, 32'h0000_4000);
        upd("R5", PA, PA, 1'b0, 32'h0000_4000);
        look("R5", PA);
        // R5 saturation at the bottom
        for (int i = 0; i < 4; i++) upd("R5", PA, PA, 1'b0, 32'h0000_4000);
        upd("R5", PA, PA, 1'b1, 32'h0000_4000);
        look("R5", PA);
        upd("R5", PA, PA, 1'b1, 32'h0000_4000);
        look("R5", PA);

        // R6 aliasing: not-taken at PB lowers PA's counter, no allocation for PB
        upd("R6", PB, PB, 1'b0, 32'h0000_9000);
        look("R6", PA);
        look("R6", PB);
        upd("R6", PB, PB, 1'b1, 32'h0000_9000);
        look("R6", PA);
        look("R6", PB);

        // R7 low address bits ignored
        look("R7", PA | 32'h3);
        upd("R7", PA | 32'h2, PA | 32'h1, 1'b1, 32'h0000_4400);
        look("R7", PA);

        // R10 refresh on taken hit, untouched on not-taken
        upd("R10", PA, PA, 1'b1, 32'h0000_5000);
        look("R10", PA);
        upd("R10", PA, PA, 1'b0, 32'h0000_6000);
        look("R10", PA);

        // R11 same-cycle update and lookup see old contents
        upd("R11", PC, PC, 1'b1, 32'h0000_7000);
        look("R11", PC);
        upd("R11", PC, PC, 1'b1, 32'h0000_7700);
        look("R11", PC);

        // R9 fill the buffer and force round-robin eviction
        for (int i = 0; i < 70; i++) begin
            logic [31:0] p;
            p = 32'h0001_0000 + 32'(i) * 32'd4;
            upd("R9", p - 32'd4, p, 1'b1, 32'h0008_0000 + 32'(i) * 32'd16);
        end
        look("R9", PA);
        look("R9", PB);
        look("R9", PC);
        for (int i = 0; i < 70; i++) look("R9", 32'h0001_0000 + 32'(i) * 32'd4);

        // R12 repeated updates of one address keep a single entry
        for (int i = 0; i < 3; i++) upd("R12", PC, PC, 1'b1, 32'h0000_A000 + 32'(i));
        look("R12", PC);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule